// File: doc/BRIEF.md
# Broadcast Channel Register Selector

This block is the address decoder and register file that sits behind a byte-wide register bus in a multi-channel device. It holds three kinds of storage: a small window of global registers at the top of the 8-bit address space, one shared register page, and one register page per channel. Pages sit at the low addresses, and all pages use the same offsets. The global window can always be reached. A global routing bit picks whether the low addresses reach the shared page or the channel pages.

With channel routing selected, a global channel mask decides which channel pages an access reaches. A write lands in every selected channel page in the same clock cycle, so firmware can program identical settings into several lanes with one bus transaction. A read returns the lowest-numbered selected channel. The register contents drive the configuration outputs of the shared logic and of each channel.

Writes take effect on the rising clock edge when the write strobe is high. Read data is combinational from the address and the current register state.

Top module: `bcast_reg_selector`

## Requirements
- R1: After a synchronous active-low reset, the channel mask is 0, channel routing is off (shared page selected), and every shared and channel register is 0x00.
- R2: The global window spans 0xEF to 0xFF and responds the same way whichever page is selected. The channel mask sits at 0xFC, bit c for channel c. The routing control sits at 0xFF, bit 0 (1 = channel pages, 0 = shared page).
- R3: Mask bits above the implemented channel count (bits 7:4 at 0xFC) ignore writes and read as 0.
- R4: With routing bit 0, a low-address write updates only the shared register at that offset, and a read returns it. No channel register changes.
- R5: With routing bit 1, a write to a channel offset updates that register in every channel whose mask bit is set, in the same cycle. Unselected channels and the shared page stay unchanged.
- R6: With routing bit 0, the mask has no effect: writes reach the shared page whatever the mask holds.
- R7: With routing bit 1 and several mask bits set, a read returns the register of the lowest-numbered selected channel.
- R8: With routing bit 1 and a mask of 0, reads of the low addresses return 0x00 and writes change nothing.
- R9: Unimplemented addresses read 0x00 and ignore writes. These are low addresses at or beyond the page depth (8 registers, offsets 0x00 to 0x07) and global addresses other than 0xFC and 0xFF.
- R10: A write takes effect at the clock edge where the strobe is sampled high. Read data and configuration outputs show the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| shr_cfg_o | output | 64 | Shared page contents, register k at bits [8k+7:8k] |
| ch_cfg_o | output | 256 | Channel page contents, channel c register k at bits [(c*8+k)*8 +: 8] |

## Verification
The hardest case to reach is a broadcast write followed by reads under a different mask. Only then do the lowest-channel priority and the untouched unselected channels show at the read port. The stimulus first writes distinct values into disjoint channel subsets. It then changes the mask to overlapping and single-channel sets and reads the same offset back. It also flips the routing bit while a full mask stays loaded, which shows that the mask is ignored on the shared page. A long stretch of random traffic, weighted toward the two control registers, then mixes mode switches with broadcast writes. A reference model tracks it cycle by cycle.

// File: rtl/bcrs_pkg.sv
// Package: shared constants and types for the broadcast channel register selector.
// Assumes an 8-bit address space with the global window at its top.
package bcrs_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    localparam addr_t GLB_BASE   = 8'hEF;
    localparam addr_t MASK_ADDR  = 8'hFC;
    localparam addr_t CTRL_ADDR  = 8'hFF;
    localparam int    CTRL_CHEN  = 0;
endpackage

// File: rtl/bcrs_global_regs.sv
// Global register window: holds the channel mask and the routing bit.
// Always decoded, whatever the page selection. Assumes NUM_CH < 8.
module bcrs_global_regs
    import bcrs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_t             addr_i,
    input  logic              wr_en_i,
    input  byte_t             wr_data_i,
    output logic [NUM_CH-1:0] mask_o,
    output logic              chen_o,
    output logic              hit_o,
    output byte_t             rd_data_o
);
    logic [NUM_CH-1:0] mask_q;
    logic              chen_q;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i;
    assign hit_o  = (addr_i >= GLB_BASE);
    assign mask_o = mask_q;
    assign chen_o = chen_q;

    // Update the mask and routing bit on writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            chen_q <= 1'b0;
        end else if (wr_en_i) begin
            if (addr_i == MASK_ADDR) mask_q <= wr_data_i[NUM_CH-1:0];
            if (addr_i == CTRL_ADDR) chen_q <= wr_data_i[CTRL_CHEN];
        end
    end

    // Return the global register at the address, zero for holes.
    always_comb begin
        rd_data_o = '0;
        if (addr_i == MASK_ADDR) rd_data_o[NUM_CH-1:0] = mask_q;
        if (addr_i == CTRL_ADDR) rd_data_o[CTRL_CHEN]  = chen_q;
    end

    AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == MASK_ADDR) |-> (rd_data_o[BYTE_W-1:NUM_CH] == '0)); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == MASK_ADDR) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/bcrs_reg_bank.sv
// One register page of DEPTH bytes with a single write port and a read port.
// Assumes DEPTH is a power of two greater than one and the caller range-checks.
module bcrs_reg_bank
    import bcrs_pkg::*;
#(
    parameter int    DEPTH = 8,
    parameter byte_t RST   = 8'h00,
    localparam int   IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  byte_t                   wr_data_i,
    output byte_t                   rd_data_o,
    output logic [DEPTH*BYTE_W-1:0] regs_o
);
    byte_t regs_q [DEPTH];

    // Store the write byte at the indexed offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= RST;
        end else if (wr_en_i) begin
            regs_q[idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = regs_q[idx_i];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o)); // R5
endmodule

// File: rtl/bcrs_read_sel.sv
// Picks the read byte of the lowest-numbered channel set in the mask.
// Returns zero and a clear any-flag when the mask is empty.
module bcrs_read_sel
    import bcrs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        mask_i,
    input  logic [NUM_CH*BYTE_W-1:0] ch_rd_i,
    output byte_t                    rd_data_o,
    output logic                     any_o
);
    logic [NUM_CH-1:0] pick;

    // Lowest set mask bit wins.
    always_comb begin
        pick      = '0;
        rd_data_o = '0;
        any_o     = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (mask_i[c] && !any_o) begin
                pick[c]   = 1'b1;
                rd_data_o = ch_rd_i[c*BYTE_W +: BYTE_W];
                any_o     = 1'b1;
            end
        end
    end

    AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick) && ((mask_i != '0) == any_o)); // R7
endmodule

// File: rtl/bcast_reg_selector.sv
// Top: decodes the address into global, shared-page and channel-page accesses,
// broadcasts channel writes to every masked channel, and muxes read data.
// Assumes SHR_REGS and CH_REGS are powers of two and smaller than GLB_BASE.
module bcast_reg_selector
    import bcrs_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SHR_REGS = 8,
    parameter int CH_REGS  = 8,
    localparam int SHR_IDX = $clog2(SHR_REGS),
    localparam int CH_IDX  = $clog2(CH_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              wr_en_i,
    input  logic [BYTE_W-1:0]                 wr_data_i,
    output logic [BYTE_W-1:0]                 rd_data_o,
    output logic [SHR_REGS*BYTE_W-1:0]        shr_cfg_o,
    output logic [NUM_CH*CH_REGS*BYTE_W-1:0]  ch_cfg_o
);
    localparam addr_t SHR_LIM = addr_t'(SHR_REGS);
    localparam addr_t CH_LIM  = addr_t'(CH_REGS);

    logic [NUM_CH-1:0]        mask;
    logic                     chen;
    logic                     glb_hit;
    byte_t                    glb_rd;
    logic                     shr_ok;
    logic                     ch_ok;
    byte_t                    shr_rd;
    logic [NUM_CH*BYTE_W-1:0] ch_rd;
    byte_t                    sel_rd;
    logic                     sel_any;

    assign shr_ok = !glb_hit && (addr_i < SHR_LIM);
    assign ch_ok  = !glb_hit && (addr_i < CH_LIM);

    bcrs_global_regs #(.NUM_CH(NUM_CH)) u_glb (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .mask_o(mask), .chen_o(chen),
        .hit_o(glb_hit), .rd_data_o(glb_rd)
    );

    bcrs_reg_bank #(.DEPTH(SHR_REGS)) u_shr (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i && shr_ok && !chen),
        .idx_i(addr_i[SHR_IDX-1:0]), .wr_data_i(wr_data_i),
        .rd_data_o(shr_rd), .regs_o(shr_cfg_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bcrs_reg_bank #(.DEPTH(CH_REGS)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en_i(wr_en_i && ch_ok && chen && mask[c]),
            .idx_i(addr_i[CH_IDX-1:0]), .wr_data_i(wr_data_i),
            .rd_data_o(ch_rd[c*BYTE_W +: BYTE_W]),
            .regs_o(ch_cfg_o[c*CH_REGS*BYTE_W +: CH_REGS*BYTE_W])
        );
    end

    bcrs_read_sel #(.NUM_CH(NUM_CH)) u_sel (
        .clk(clk), .rst_n(rst_n), .mask_i(mask), .ch_rd_i(ch_rd),
        .rd_data_o(sel_rd), .any_o(sel_any)
    );

    // Route read data from the global window or the selected page.
    always_comb begin
        if (glb_hit)     rd_data_o = glb_rd;
        else if (chen)   rd_data_o = ch_ok  ? sel_rd : '0;
        else             rd_data_o = shr_ok ? shr_rd : '0;
    end

    AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        chen |=> $stable(shr_cfg_o)); // R4
    AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !chen |=> $stable(ch_cfg_o)); // R6
    AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (chen && !sel_any && !glb_hit) |-> (rd_data_o == '0)); // R8
    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_hit && !ch_ok && !shr_ok) |-> (rd_data_o == '0)); // R9
endmodule

// File: tb/bcast_reg_selector_tb.sv
// Bench: behavioural reference model compared with the design on every cycle.
module bcast_reg_selector_tb;
    localparam int NCH = 4;
    localparam int NSH = 8;
    localparam int NCR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic we = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic [NSH*8-1:0] shr_cfg;
    logic [NCH*NCR*8-1:0] ch_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_shr [NSH];
    int m_ch  [NCH][NCR];
    int m_mask;
    int m_chen;

    always #2.5 clk = ~clk;

    bcast_reg_selector u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we),
        .wr_data_i(wd), .rd_data_o(rd), .shr_cfg_o(shr_cfg), .ch_cfg_o(ch_cfg)
    );

    function automatic void m_reset();
        for (int i = 0; i < NSH; i++) m_shr[i] = 0;
        for (int c = 0; c < NCH; c++) for (int i = 0; i < NCR; i++) m_ch[c][i] = 0;
        m_mask = 0;
        m_chen = 0;
    endfunction

    function automatic int m_read(int a);
        if (a == 'hFC) return m_mask;
        if (a == 'hFF) return m_chen;
        if (a >= 'hEF) return 0;
        if (m_chen == 0) return (a < NSH) ? m_shr[a] : 0;
        if (a >= NCR) return 0;
        for (int c = 0; c < NCH; c++) if (m_mask[c]) return m_ch[c][a];
        return 0;
    endfunction

    function automatic void m_write(int a, int d);
        if (a == 'hFC) m_mask = d & 'hF;
        else if (a == 'hFF) m_chen = d & 1;
        else if (a < 'hEF) begin
            if (m_chen == 0) begin
                if (a < NSH) m_shr[a] = d;
            end else if (a < NCR) begin
                for (int c = 0; c < NCH; c++) if (m_mask[c]) m_ch[c][a] = d;
            end
        end
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_cfg(string req);
        logic [NSH*8-1:0]     es;
        logic [NCH*NCR*8-1:0] ec;
        for (int i = 0; i < NSH; i++) es[i*8 +: 8] = 8'(m_shr[i]);
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < NCR; i++) ec[(c*NCR+i)*8 +: 8] = 8'(m_ch[c][i]);
        n_tests++;
        if (shr_cfg !== es || ch_cfg !== ec) begin
            n_fail++;
            $display("FAIL %s: cfg actual %h/%h expected %h/%h", req, shr_cfg, ch_cfg, es, ec);
        end
    endtask

    // One bus cycle: drive at negedge, compare read and outputs, then apply model.
    task automatic cyc(string req, int a, bit w, int d);
        @(negedge clk);
        addr = 8'(a); we = w; wd = 8'(d);
        #1;
        check(req, int'(rd), m_read(a));
        check_cfg(req);
        @(posedge clk);
        if (w) m_write(a, d);
    endtask

    task automatic rd_(string req, int a); cyc(req, a, 1'b0, 0); endtask
    task automatic wr_(string req, int a, int d); cyc(req, a, 1'b1, d); endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd_("R1", 'hFC); rd_("R1", 'hFF); rd_("R1", 'h00); rd_("R1", 'h07);
        // R4 shared page access
        wr_("R4", 'h03, 'h5A); rd_("R10", 'h03); wr_("R4", 'h00, 'hC3); rd_("R4", 'h00);
        // R2 routing and mask registers
        wr_("R2", 'hFF, 'h01); rd_("R2", 'hFF); rd_("R2", 'hFC);
        // R3 reserved mask bits
        wr_("R3", 'hFC, 'hF5); rd_("R3", 'hFC);
        // R5 broadcast to ch0 and ch2
        wr_("R5", 'h02, 'h3C); rd_("R5", 'h02); rd_("R4", 'h03);
        // R7 lowest channel priority
        wr_("R7", 'hFC, 'h0A); wr_("R5", 'h02, 'h77);
        wr_("R7", 'hFC, 'h0C); rd_("R7", 'h02);
        wr_("R7", 'hFC, 'h0E); rd_("R7", 'h02);
        wr_("R7", 'hFC, 'h08); rd_("R7", 'h02);
        // R8 empty mask
        wr_("R8", 'hFC, 'h00); rd_("R8", 'h02); wr_("R8", 'h02, 'hFF); rd_("R8", 'h02);
        // R2 global window still visible in channel mode
        rd_("R2", 'hFF); rd_("R2", 'hEF);
        // R6 mask ignored with shared routing
        wr_("R6", 'hFC, 'h0F); wr_("R6", 'hFF, 'h00); wr_("R6", 'h02, 'h99);
        rd_("R6", 'h02); wr_("R6", 'hFF, 'h01); rd_("R6", 'h02);
        // R9 holes
        wr_("R9", 'h08, 'h11); rd_("R9", 'h08); wr_("R9", 'hF0, 'h22); rd_("R9", 'hF0);
        wr_("R9", 'h80, 'h33); rd_("R9", 'h80); wr_("R9", 'hEF, 'h44); rd_("R9", 'hEF);
        // R5 random mixed traffic
        for (int k = 0; k < 600; k++) begin
            int sel = int'($urandom_range(0, 9));
            int a;
            if (sel == 0) a = 'hFC;
            else if (sel == 1) a = 'hFF;
            else if (sel == 2) a = int'($urandom_range('hEF, 'hFF));
            else a = int'($urandom_range(0, 9));
            cyc("R5", a, 1'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
        end
        // R1 reset again from a busy state
        @(negedge clk) rst_n = 1'b0; we = 1'b0;
        @(posedge clk); m_reset();
        @(negedge clk) rst_n = 1'b1;
        rd_("R1", 'hFF); rd_("R1", 'hFC); rd_("R1", 'h02);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule